// File: doc/BRIEF.md
# Toggle-Refreshed Watchdog Timer with Selectable Timeout

This block is a watchdog timer that a host keeps alive through ordinary register writes. Each write arrives as a decoded strobe with a 4-bit address and an 8-bit data byte. Bit 7 of every write is the keep-alive bit. A refresh happens only when that bit differs from the one carried by the previous write, at whatever address. A write that repeats the old value refreshes nothing. A separate 1 ms tick input paces the count. When the number of ticks since the last refresh reaches the selected period, a sticky timeout flag goes high for a downstream fail-safe controller.

The period is chosen by a 2-bit code written at the configuration address. The code is first stored as pending and becomes active only when a new count sequence starts, that is, on a refresh. This lets the host program a new period and then start it cleanly with a toggle. A second address does nothing at all except carry the keep-alive bit. In a daisy chain the host can then refresh the watchdog without touching any setting.

The write strobe is a plain control input with no back-pressure: every strobed write is taken in the cycle it is presented. The block has no ready signal and never stalls.

Top module: `wdt_refresh_timer`

## Requirements
- R1: After reset, `expired` is 0, the count is 0, the stored keep-alive bit is 0 and the active and pending codes are both 2'b00. With no writes, `expired` therefore rises after 620 ticks.
- R2: The active code selects the period in ticks as follows: 2'b10 gives 2500, 2'b00 gives 620, 2'b11 gives 1250 and 2'b01 gives 310.
- R3: A write at any address whose bit 7 differs from the stored keep-alive bit is a refresh. It clears the count and `expired`. Every write stores its bit 7. A write whose bit 7 equals the stored bit changes neither the count nor `expired`.
- R4: A write to address 4'b1101 stores data bits 1:0 as the pending code. The active code changes only on a refresh, where it takes the pending code. If the refreshing write is itself to 4'b1101, the active code takes the code carried in that write.
- R5: A write to address 4'b0110 changes neither the pending code nor the active code, whatever its bits 1:0. A bit-7 toggle written there still refreshes.
- R6: The count advances by one on each cycle with `tick_ms` high and stays put otherwise. `expired` is set on the clock edge that samples the tick making the count equal to the active period.
- R7: Once set, `expired` stays high and the count stops advancing until a refresh or a reset.
- R8: When a refresh and a tick arrive in the same cycle, the refresh wins and the count becomes 0.
- R9: Writes to addresses other than 4'b1101 change no code. They act only through their bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data; bit 7 is the keep-alive bit, bits 1:0 the timeout code at 4'b1101 |
| tick_ms | input | 1 | One-cycle 1 ms time base pulse |
| expired | output | 1 | Sticky timeout flag |

## Verification
Every result is registered. A refresh, a code change or a tick sampled at one rising edge shows on `expired` right after that same edge, with no further delay. The bench drives inputs at the falling edge and updates its own model for the rising edge that follows. It compares `expired` one time unit after that rising edge on every cycle, so the first cycle of a timeout and the first cycle after a refresh are both caught exactly. Directed runs place the P-1 and P tick boundaries of each code. Seeded random writes and ticks then cover the rest of the state space.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_CODES = 4;
  localparam logic [3:0] WDT_ADDR_CFG = 4'b1101;
  localparam logic [3:0] WDT_ADDR_NOP = 4'b0110;
  localparam int unsigned WDT_KEEP_BIT = 7;
  typedef logic [1:0] wdt_code_t;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       refresh,
  output wdt_code_t  pend_code,
  output wdt_code_t  act_code,
  output logic       last_bit
);
  logic      keep_q;
  wdt_code_t pend_q, act_q;
  logic      cfg_hit;

  assign cfg_hit = wr_en && (wr_addr == WDT_ADDR_CFG);
  assign refresh = wr_en && (wr_data[WDT_KEEP_BIT] != keep_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_en) keep_q <= wr_data[WDT_KEEP_BIT];
      if (cfg_hit) pend_q <= wr_data[1:0];
      if (refresh) act_q <= cfg_hit ? wr_data[1:0] : pend_q;
    end
  end

  assign pend_code = pend_q;
  assign act_code  = act_q;
  assign last_bit  = keep_q;
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned TMO_00 = 620,
  parameter int unsigned TMO_01 = 310,
  parameter int unsigned TMO_10 = 2500,
  parameter int unsigned TMO_11 = 1250
) (
  input  wdt_code_t          code,
  output logic [CNT_W-1:0]   limit
);
  logic [CNT_W-1:0] lut [WDT_CODES];

  assign lut[0] = CNT_W'(TMO_00);
  assign lut[1] = CNT_W'(TMO_01);
  assign lut[2] = CNT_W'(TMO_10);
  assign lut[3] = CNT_W'(TMO_11);

  assign limit = lut[code];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             exp_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick && !exp_q) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt >= limit) exp_q <= 1'b1;
    end
  end

  assign count   = cnt_q;
  assign expired = exp_q;
endmodule

// File: rtl/wdt_refresh_timer.sv
module wdt_refresh_timer
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_00 = 620,
  parameter int unsigned TMO_01 = 310,
  parameter int unsigned TMO_10 = 2500,
  parameter int unsigned TMO_11 = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       tick_ms,
  output logic       expired
);
  localparam int unsigned MAX_LO = (TMO_00 > TMO_01) ? TMO_00 : TMO_01;
  localparam int unsigned MAX_HI = (TMO_10 > TMO_11) ? TMO_10 : TMO_11;
  localparam int unsigned MAX_T  = (MAX_LO > MAX_HI) ? MAX_LO : MAX_HI;
  localparam int unsigned CNT_W  = $clog2(MAX_T + 1);

  logic             refresh;
  wdt_code_t        pend_code, act_code;
  logic             last_bit;
  logic [CNT_W-1:0] limit, count_q;

  wdt_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .refresh(refresh), .pend_code(pend_code),
    .act_code(act_code), .last_bit(last_bit)
  );

  wdt_period_sel #(
    .CNT_W(CNT_W), .TMO_00(TMO_00), .TMO_01(TMO_01),
    .TMO_10(TMO_10), .TMO_11(TMO_11)
  ) u_sel (
    .code(act_code), .limit(limit)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(refresh), .tick(tick_ms),
    .limit(limit), .count(count_q), .expired(expired)
  );
endmodule

// File: rtl/wdt_refresh_checker.sv
module wdt_refresh_checker
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             tick_ms,
  input logic             expired,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input wdt_code_t        act_code,
  input wdt_code_t        pend_code,
  input logic             last_bit
);
  logic toggled;
  assign toggled = wr_en && (wr_data[7] != last_bit);

  assert_refresh_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    toggled |=> (!expired && count == '0));

  assert_keep_bit_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (last_bit == $past(wr_data[7])));

  assert_active_only_on_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !toggled |=> $stable(act_code));

  assert_nop_keeps_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == WDT_ADDR_NOP) |=> $stable(pend_code));

  assert_idle_holds_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms && !toggled) |=> $stable(count));

  assert_rise_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> (count == limit));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !toggled) |=> (expired && $stable(count)));
endmodule

bind wdt_refresh_timer wdt_refresh_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick_ms(tick_ms), .expired(expired),
  .count(count_q), .limit(limit), .act_code(act_code),
  .pend_code(pend_code), .last_bit(last_bit)
);

// File: tb/test_wdt_refresh_timer.sv
module test_wdt_refresh_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CFG = 4'b1101;
  localparam logic [3:0] A_NOP = 4'b0110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_ms = 1'b0;
  logic       expired;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // model state
  bit       m_last = 1'b0;
  bit [1:0] m_pend = 2'b00;
  bit [1:0] m_act = 2'b00;
  int       m_ticks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_refresh_timer i_wdt_refresh_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_ms(tick_ms), .expired(expired)
  );

  function automatic int period_of(input bit [1:0] c);
    case (c)
      2'b00: return 620;
      2'b01: return 310;
      2'b10: return 2500;
      default: return 1250;
    endcase
  endfunction

  function automatic bit exp_model();
    return m_ticks >= period_of(m_act);
  endfunction

  task automatic check(input bit got, input bit want, input string req);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: expired=%0d expected=%0d at %0t", req, got, want, $time);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d, input bit tk);
    bit tog;
    bit [1:0] np;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick_ms = tk;
    @(posedge clk);
    tog = we && (d[7] != m_last);
    if (we) m_last = d[7];
    np = (we && a == A_CFG) ? d[1:0] : m_pend;
    if (tog) begin
      m_act = (we && a == A_CFG) ? d[1:0] : m_pend;
      m_ticks = 0;
    end else if (tk && !exp_model()) begin
      m_ticks++;
    end
    m_pend = np;
    #1;
    check(expired, exp_model(), cur_req);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, 1'b1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(expired, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: default code 00 expires after 620 ticks
    cur_req = "R1 R2 code00";
    ticks(619);
    check(expired, 1'b0, "R1 619 ticks");
    ticks(1);
    check(expired, 1'b1, "R2 620 ticks");

    // R7: sticky while ticking, no refresh
    cur_req = "R7 sticky";
    ticks(50);
    wr(4'h3, 8'h00);               // same bit 7, no refresh
    check(expired, 1'b1, "R7 same-bit write");

    // R3: toggle at a plain address refreshes
    cur_req = "R3 toggle";
    wr(4'h3, 8'h80);
    check(expired, 1'b0, "R3 refresh clears");
    ticks(300);
    wr(4'h0, 8'h80);               // no toggle: count continues
    ticks(319);
    check(expired, 1'b0, "R3 no-toggle write kept count");
    ticks(1);
    check(expired, 1'b1, "R3 expiry on schedule");

    // R4: pending code waits for a refresh
    cur_req = "R4 pending";
    wr(4'h0, 8'h00);               // refresh, active stays 00
    wr(A_CFG, 8'h81);              // pending 01, bit7 1 -> refresh adopts 01
    ticks(309);
    check(expired, 1'b0, "R4 code01 309");
    ticks(1);
    check(expired, 1'b1, "R4 code01 310");
    wr(A_CFG, 8'h82);              // same bit7: pending 10 only
    wr(4'h0, 8'h80);               // no toggle
    check(expired, 1'b1, "R4 no adoption without refresh");

    // R5: NOP address toggles, keeps codes
    cur_req = "R5 nop";
    wr(A_NOP, 8'h03);              // toggle 1->0, active <= pending 10
    ticks(1250);
    check(expired, 1'b0, "R5 nop keeps pending 10");
    ticks(1250);
    check(expired, 1'b1, "R5 code10 2500");
    wr(A_NOP, 8'h81);              // toggle, data bits ignored
    ticks(2500);
    check(expired, 1'b1, "R5 nop bits ignored");

    // R9 and code 11
    cur_req = "R9 other addr";
    wr(A_CFG, 8'h03);              // toggle, active 11
    wr(4'h5, 8'h01);               // no code effect
    ticks(1249);
    check(expired, 1'b0, "R2 code11 1249");
    ticks(1);
    check(expired, 1'b1, "R2 code11 1250");

    // R6: no tick, no advance
    cur_req = "R6 idle";
    wr(4'h0, 8'h80);
    for (int i = 0; i < 2000; i++) step(1'b0, 4'h0, 8'h00, 1'b0);
    check(expired, 1'b0, "R6 idle no advance");

    // R8: refresh with tick
    cur_req = "R8 collide";
    ticks(1249);
    step(1'b1, 4'h2, 8'h00, 1'b1);
    check(expired, 1'b0, "R8 refresh beats tick");
    ticks(1249);
    check(expired, 1'b0, "R8 count restarted at 0");
    ticks(1);
    check(expired, 1'b1, "R8 expiry after restart");

    // random phase
    cur_req = "R3 R4 R5 R6 random";
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 60000; i++) begin
      bit we = ($urandom % 512) == 0;
      bit tk = ($urandom % 4) != 0;
      int s = $urandom % 3;
      logic [3:0] a = (s == 0) ? A_CFG : (s == 1) ? A_NOP : 4'($urandom);
      logic [7:0] d = 8'($urandom);
      d[7] = (($urandom % 4) == 0) ? ~m_last : m_last;
      step(we, a, d, tk);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule